// File: doc/BRIEF.md
# Strobe Watchdog With Undriven-Pin Detection

This block supervises a software strobe line. Every change of level on the line, rising or falling, counts as a kick. If the line holds one level for a whole timeout window, the active-low watchdog output goes low. It stays low until the next kick, or until the system reset state is asserted. While the supply-good flag is low, the output is held low whatever the timer says. The timer is held cleared while the system is in reset and starts counting once reset ends.

The block also tells whether anyone is driving the strobe line. It steers a weak pull on the pad through a repeating pattern. The pull points down for seven eighths of every timeout window and up for the final eighth. If the sensed level follows the pull through a complete down phase and then a complete up phase, the line is taken to be undriven. The timeout is then suspended and the output is kept high. As soon as the sensed level opposes the pull, the line counts as driven again and timeout checking resumes.

The pad level arrives asynchronously and passes through a flop synchroniser. One clock cycle is one timer tick. The timeout length is a parameter.

Top module: `strobe_watchdog`

## Requirements
- R1: A level change on `strobe_pin` in either direction restarts the timeout. A change applied just after rising edge 0 clears a pending expiry so that `wdog_n` is high after edge 4.
- R2: If `strobe_pin` has no level change, `wdog_n` is still high after edge TIMEOUT_TICKS+3 and low after edge TIMEOUT_TICKS+4, counted from the last change.
- R3: While `sys_in_reset` is 1 the timer stays cleared. Counting starts on the first edge with `sys_in_reset` at 0. Without kicks, `wdog_n` is high after edge TIMEOUT_TICKS and low after edge TIMEOUT_TICKS+1 of that release.
- R4: When `supply_good` is 0 at a rising edge, `wdog_n` is 0 after that edge, regardless of timer, reset state or pin state.
- R5: Asserting `sys_in_reset` clears an expiry, and `wdog_n` returns to 1 two edges later if the supply is good.
- R6: A strobe level held for a single clock cycle is seen as two transitions and restarts the timeout.
- R7: After reset, `pull_up_en` (1 = pull up, 0 = pull down) is 1 when (edges since reset) mod TIMEOUT_TICKS lies in the last TIMEOUT_TICKS/PULL_DIV positions, and 0 otherwise. The pattern repeats without end.
- R8: Once the sensed level has matched the pull direction through a full down phase followed by a full up phase, the timer is suspended and `wdog_n` stays 1 while the supply is good. The first SYNC_STAGES+1 cycles of each phase are not compared.
- R9: A sensed level that opposes the pull direction, outside those guard cycles, marks the line as driven, and timeout checking resumes.
- R10: After the synchronous reset `rst`, `wdog_n` is 1 and `pull_up_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one timer tick |
| rst | input | 1 | Synchronous active-high reset of the block |
| strobe_pin | input | 1 | Sensed pad level of the strobe line (asynchronous) |
| sys_in_reset | input | 1 | 1 while the supervised system is in reset; holds the timer cleared |
| supply_good | input | 1 | 0 forces the watchdog output low |
| wdog_n | output | 1 | Active-low watchdog output, registered |
| pull_up_en | output | 1 | Weak pull direction for the pad: 1 up, 0 down |

## Verification
The strobe is driven with several patterns. A lone rising change and a lone falling change each pin the expiry to an exact edge, which tells whether both polarities restart the count. A one-cycle pulse checks that the narrowest level the synchroniser can see still kicks. A line left at its level after reset, and again after a reset-state pulse, measures the count from release. Finally the line is released so that it follows the pull, and then driven high against it. These two cases separate an undriven line, which must keep the output high, from a driven but silent line, which must time out. Supply drops during an expiry and during an undriven period check that the forced-low path overrides both.

// File: rtl/swd_pkg.sv
package swd_pkg;

  // Progress of the undriven-line probe.
  typedef enum logic [1:0] {
    PRB_UNSURE   = 2'd0,  // nothing proven yet, or line seen driven
    PRB_LOW_SEEN = 2'd1,  // one clean pull-down phase seen
    PRB_FLOATING = 2'd2   // clean down and up phases seen: line undriven
  } probe_state_t;

  // Length of the pull-up slice of a pattern period.
  function automatic int unsigned up_slice(input int unsigned period,
                                           input int unsigned div);
    return period / div;
  endfunction

endpackage

// File: rtl/swd_sync_edge.sv
module swd_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic kick
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // Flop chain into the clock domain; bit 0 samples the pad.
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  // A change between consecutive synchronised samples is a kick.
  assign kick  = chain_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/swd_timeout.sv
module swd_timeout #(
  parameter int unsigned TICKS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic kick,
  output logic expired
);

  localparam int unsigned CW = $clog2(TICKS);
  localparam logic [CW-1:0] LIMIT = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt_q   <= '0;
      expired <= 1'b0;
    end else if (kick) begin
      cnt_q   <= '0;
      expired <= 1'b0;
    end else if (cnt_q == LIMIT) begin
      expired <= 1'b1;       // sticky until the next kick or hold
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/swd_float_probe.sv
module swd_float_probe
  import swd_pkg::*;
#(
  parameter int unsigned PERIOD = 1024,
  parameter int unsigned DIV    = 8,
  parameter int unsigned GUARD  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sensed,
  output logic pull_up,
  output logic floating
);

  localparam int unsigned UP_LEN = up_slice(PERIOD, DIV);
  localparam int unsigned DN_LEN = PERIOD - UP_LEN;
  localparam int unsigned PW     = $clog2(PERIOD);
  localparam logic [PW-1:0] DN_END   = PW'(DN_LEN - 1);
  localparam logic [PW-1:0] UP_END   = PW'(PERIOD - 1);
  localparam logic [PW-1:0] DN_CMP   = PW'(GUARD);
  localparam logic [PW-1:0] UP_CMP   = PW'(DN_LEN + GUARD);

  logic [PW-1:0] pos_q;
  probe_state_t  state_q;
  logic          clean_q;
  logic          cmp_en, mismatch, end_dn, end_up;

  assign end_dn   = (pos_q == DN_END);
  assign end_up   = (pos_q == UP_END);
  assign cmp_en   = pull_up ? (pos_q >= UP_CMP) : (pos_q >= DN_CMP);
  assign mismatch = cmp_en && (sensed != pull_up);

  // Free-running pattern position and registered pull direction.
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      pull_up <= 1'b0;
    end else begin
      pos_q <= end_up ? '0 : pos_q + 1'b1;
      if (end_dn)      pull_up <= 1'b1;
      else if (end_up) pull_up <= 1'b0;
    end
  end

  // Per-phase cleanliness and the driven/undriven verdict.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PRB_UNSURE;
      clean_q <= 1'b1;
    end else begin
      clean_q <= (end_dn || end_up) ? 1'b1 : (clean_q & ~mismatch);
      if (mismatch)
        state_q <= PRB_UNSURE;
      else if (end_dn && clean_q && state_q == PRB_UNSURE)
        state_q <= PRB_LOW_SEEN;
      else if (end_up && clean_q && state_q == PRB_LOW_SEEN)
        state_q <= PRB_FLOATING;
    end
  end

  assign floating = (state_q == PRB_FLOATING);

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int unsigned TIMEOUT_TICKS = 1024,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned PULL_DIV      = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_pin,
  input  logic sys_in_reset,
  input  logic supply_good,
  output logic wdog_n,
  output logic pull_up_en
);

  localparam int unsigned GUARD_TICKS = SYNC_STAGES + 1;

  logic level, kick, floating, expired;

  swd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin   (strobe_pin),
    .level (level),
    .kick  (kick)
  );

  swd_timeout #(.TICKS(TIMEOUT_TICKS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .hold    (sys_in_reset | floating),
    .kick    (kick),
    .expired (expired)
  );

  swd_float_probe #(
    .PERIOD (TIMEOUT_TICKS),
    .DIV    (PULL_DIV),
    .GUARD  (GUARD_TICKS)
  ) u_probe (
    .clk      (clk),
    .rst      (rst),
    .sensed   (level),
    .pull_up  (pull_up_en),
    .floating (floating)
  );

  always_ff @(posedge clk) begin
    if (rst) wdog_n <= 1'b1;
    else     wdog_n <= supply_good & ~expired;
  end

endmodule

// File: rtl/swd_checker.sv
module swd_checker (
  input logic clk,
  input logic rst,
  input logic supply_good,
  input logic sys_in_reset,
  input logic wdog_n,
  input logic kick,
  input logic floating,
  input logic expired
);

  // R1: a kick clears any expiry on the next edge
  a_r1_kick_clears: assert property (@(posedge clk) disable iff (rst)
    kick |=> !expired);

  // R2: an expiry persists while nothing clears it
  a_r2_expiry_sticky: assert property (@(posedge clk) disable iff (rst)
    (expired && !kick && !sys_in_reset && !floating) |=> expired);

  // R3: the reset state keeps the timer from expiring
  a_r3_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    sys_in_reset |=> !expired);

  // R4: low supply forces the output active
  a_r4_supply_forces_low: assert property (@(posedge clk) disable iff (rst)
    !supply_good |=> !wdog_n);

  // R8: an undriven line suspends the timeout
  a_r8_float_suspends: assert property (@(posedge clk) disable iff (rst)
    floating |=> !expired);

endmodule

bind strobe_watchdog swd_checker u_swd_chk (
  .clk          (clk),
  .rst          (rst),
  .supply_good  (supply_good),
  .sys_in_reset (sys_in_reset),
  .wdog_n       (wdog_n),
  .kick         (kick),
  .floating     (floating),
  .expired      (expired)
);

// File: tb/test_strobe_watchdog.sv
module test_strobe_watchdog;

  localparam int T  = 64;
  localparam int HI = T / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sys_in_reset = 1'b1;
  logic supply_good = 1'b1;
  logic drive_en = 1'b1;
  logic drive_val = 1'b0;
  logic strobe_pin;
  logic wdog_n, pull_up_en;

  // Pad model: driven when enabled, else follows the weak pull.
  assign strobe_pin = drive_en ? drive_val : pull_up_en;

  always #10 clk = ~clk;   // 50 MHz

  strobe_watchdog #(.TIMEOUT_TICKS(T)) i_strobe_watchdog (
    .clk          (clk),
    .rst          (rst),
    .strobe_pin   (strobe_pin),
    .sys_in_reset (sys_in_reset),
    .supply_good  (supply_good),
    .wdog_n       (wdog_n),
    .pull_up_en   (pull_up_en)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    bit    sel;   // 0: wdog_n, 1: pull_up_en
    bit    val;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Driver side: schedule an expected value d edges from now.
  task automatic expect_at(input int d, input bit sel, input bit v, input string tag);
    exp_t e;
    e.at = cyc + d; e.sel = sel; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare scheduled items away from the active edge.
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        logic act;
        act = q[i].sel ? pull_up_en : wdog_n;
        n_cmp++;
        if (act !== q[i].val) begin
          n_bad++;
          $display("FAIL %s: actual %0b expected %0b at edge %0d",
                   q[i].tag, act, q[i].val, cyc);
        end
        q.delete(i);
      end
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    step(3);
    expect_at(1, 0, 1'b1, "R10 wdog_n after reset");
    expect_at(1, 1, 1'b0, "R10 pull_up_en after reset");
    step(2);
    rst = 1'b0;
    // R7: two full pull periods from reset release
    for (int k = 1; k <= 2 * T; k++)
      expect_at(k, 1, ((k % T) >= T - HI), "R7 pull pattern");
    expect_at(100, 0, 1'b1, "R3 timer held in reset state");
    step(100);

    // R3: count from release of the reset state
    sys_in_reset = 1'b0;
    expect_at(T,     0, 1'b1, "R3 still high before expiry");
    expect_at(T + 1, 0, 1'b0, "R3 expiry after release");
    step(T + 5);

    // R1: rising change clears the expiry
    drive_val = 1'b1;
    expect_at(3, 0, 1'b0, "R1 low before kick lands");
    expect_at(4, 0, 1'b1, "R1 rising kick restores high");
    step(4);
    // R2: falling change restarts the full window
    drive_val = 1'b0;
    expect_at(T + 3, 0, 1'b1, "R2 high at last tick");
    expect_at(T + 4, 0, 1'b0, "R2 timeout after falling kick");
    step(T + 6);

    // R6: one-cycle pulse
    expect_at(3,     0, 1'b0, "R6 low before pulse seen");
    expect_at(4,     0, 1'b1, "R6 pulse restores high");
    expect_at(T + 4, 0, 1'b1, "R6 high before second-edge timeout");
    expect_at(T + 5, 0, 1'b0, "R6 timeout from trailing edge");
    drive_val = 1'b1;
    step(1);
    drive_val = 1'b0;
    step(T + 8);

    // R5: reset state clears an expiry
    sys_in_reset = 1'b1;
    expect_at(1, 0, 1'b0, "R5 one edge after hold");
    expect_at(2, 0, 1'b1, "R5 hold restores high");
    step(3);
    // R4: supply low overrides
    supply_good = 1'b0;
    expect_at(1, 0, 1'b0, "R4 low supply forces low");
    step(3);
    supply_good = 1'b1;
    expect_at(1, 0, 1'b1, "R4 recovers with supply");
    step(2);
    sys_in_reset = 1'b0;
    expect_at(T,     0, 1'b1, "R3 high before second expiry");
    expect_at(T + 1, 0, 1'b0, "R3 expiry after second release");
    step(T + 3);

    // R8: release the line; it follows the pull
    drive_en = 1'b0;
    for (int j = 0; j < 16; j++)
      expect_at(80 + 16 * j, 0, 1'b1, "R8 undriven line keeps output high");
    step(340);
    supply_good = 1'b0;
    expect_at(1, 0, 1'b0, "R4 low supply while undriven");
    step(2);
    supply_good = 1'b1;
    expect_at(2, 0, 1'b1, "R8 still suspended after supply returns");
    step(4);

    // R9: drive against the pull, silent line must time out
    drive_en  = 1'b1;
    drive_val = 1'b1;
    expect_at(2 * T, 0, 1'b0, "R9 driven silent line times out");
    expect_at(3 * T, 0, 1'b0, "R9 stays expired while driven");
    step(3 * T + 2);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

endmodule